// File: doc/BRIEF.md
# Deep Standby Wake-Up Sequencer

This block is the power-management controller that puts the chip into a deep standby stop state and brings it back out. While the chip runs, a request to enter standby is accepted only when no enabled wake source is already active. Once in standby, the block watches a small set of wake sources. These are a low level on the external reset pin, a low-voltage reset, a low-voltage interrupt that is enabled for return, and a wake pin. The watchdog, clock-supervisor and frequency-detector reset requests are masked while the chip is in standby. While it runs, they are passed on to the core reset request.

Any accepted wake source starts a fixed return sequence. First the regulator gets a programmable settle interval. Next the block waits until both on-chip RC oscillators report ready. Last comes a four-cycle transition reset. After the return, the clock select is forced to the fast RC oscillator whatever mode was selected before. A sticky cause register records which sources ended standby. The wake pin, the reset pin and both low-voltage inputs pass through two-flip-flop synchronisers before the controller acts on them.

Top module: `dstby_wake_seq`

## Requirements
- R1: In standby, a synchronised wake source moves the controller to the regulator wait on the next edge: a low on `rst_pin_n`, a high on `lvd_rst`, or a high on `wake_pin`. Each such input reaches the controller two clock edges after it is sampled, so a single-cycle pulse is enough to wake.
- R2: In standby, `swdt_rst`, `hwdt_rst`, `csv_rst` and `fdet_rst` neither end standby nor raise `core_rst_req`. While running, any of them raises `core_rst_req` in the same cycle.
- R3: `lvd_irq` counts as a wake source only when `lvd_irq_ret_en` and `lvd_irq_en` are both 1.
- R4: `reg_lp_mode` is high only in standby. The regulator wait that follows lasts max(`reg_settle_cycles`,1) cycles, and during that time both oscillator enables stay low.
- R5: The oscillator wait lasts until `hrc_ready` and `lrc_ready` are both high. `hrc_en` and `lrc_en` are low in standby and in the regulator wait, and high in every other state.
- R6: The oscillator wait is followed by exactly 4 cycles of `xfer_rst` high. `standby_o` is high from standby entry through the oscillator wait, and it is low while `xfer_rst` is high.
- R7: `clk_sel` equals `clk_mode_req`, except while the force flag is set, when it reads 2'b00 (fast RC). The flag is set by reset and on entry to the transition reset. It is cleared when the controller is running and `clk_mode_req` is 2'b00.
- R8: A standby request made while any enabled wake source is active (after synchronisation) is refused, and the controller stays running.
- R9: `wake_cause` bit 0 is the reset pin, bit 1 the low-voltage reset, bit 2 the low-voltage interrupt and bit 3 the wake pin. Bits are set for every source active on the edge that ends standby. They are cleared only by writing 1 to `cause_clr`, and a set wins over a clear in the same cycle.
- R10: After reset the controller is running, `wake_cause` is 0, `clk_sel` is 2'b00, both oscillator enables are high and `xfer_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_req | input | 1 | Request to enter deep standby |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| lvd_rst | input | 1 | Low-voltage reset, asynchronous |
| lvd_irq | input | 1 | Low-voltage interrupt, asynchronous |
| lvd_irq_ret_en | input | 1 | Return enable for the low-voltage interrupt |
| lvd_irq_en | input | 1 | Low-voltage interrupt enable |
| wake_pin | input | 1 | Wake pin, active high, asynchronous |
| swdt_rst | input | 1 | Software watchdog reset request |
| hwdt_rst | input | 1 | Hardware watchdog reset request |
| csv_rst | input | 1 | Clock-supervisor reset request |
| fdet_rst | input | 1 | Abnormal-frequency reset request |
| reg_settle_cycles | input | CNT_W | Regulator settle length in cycles |
| hrc_ready | input | 1 | Fast RC oscillator stable |
| lrc_ready | input | 1 | Slow RC oscillator stable |
| clk_mode_req | input | 2 | Clock mode selected by software |
| cause_clr | input | 4 | Write-one-to-clear strobe for wake_cause |
| standby_o | output | 1 | Chip is in standby or returning |
| reg_lp_mode | output | 1 | Regulator held in low-power mode |
| hrc_en | output | 1 | Fast RC oscillator enable |
| lrc_en | output | 1 | Slow RC oscillator enable |
| xfer_rst | output | 1 | Transition reset pulse |
| clk_sel | output | 2 | Effective clock select |
| core_rst_req | output | 1 | Pass-through of the watchdog and supervisor resets while running |
| wake_cause | output | 4 | Sticky wake-cause bits |

## Verification
The bench targets the following corner cases:
- Masked resets raised during standby. A design that let them through would leave standby or pulse the core reset.
- The low-voltage interrupt with only one of its two enables set. A wrong gate would wake the chip.
- A one-cycle wake pulse, which is lost if the synchroniser drops it.
- A regulator settle length of 0 or 1, where an off-by-one counter would stall or skip the wait.
- Oscillators that become ready one at a time. A design that checks only one of them would start the transition reset early.
- A standby request while a wake source is active, which a faulty design would accept and then stick in standby.
- A clear strobe held across the capture edge, which exposes the wrong set/clear priority.
- The forced fast-RC select. A design that got this wrong would return to the old clock mode after the transition reset.

// File: rtl/dstby_pkg.sv
package dstby_pkg;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_STBY = 3'd1,
        ST_REGW = 3'd2,
        ST_OSCW = 3'd3,
        ST_XRST = 3'd4
    } dstby_state_e;

    // bit 0 pin reset, bit 1 lvd reset, bit 2 lvd irq, bit 3 wake pin
    typedef struct packed {
        logic wake_pin;
        logic lvd_irq;
        logic lvd_rst;
        logic pin_rst;
    } wake_cause_t;

    localparam logic [1:0] CLK_HRC   = 2'b00;
    localparam int         XRST_CYC  = 4;
    localparam int         CAUSE_W   = $bits(wake_cause_t);

    function automatic logic cause_any(input wake_cause_t c);
        return |c;
    endfunction

endpackage

// File: rtl/dstby_sync2.sv
module dstby_sync2 #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] ff;
        always_ff @(posedge clk) begin
            if (rst) ff <= {2{RST_VAL[i]}};
            else     ff <= {ff[0], d[i]};
        end
        assign q[i] = ff[1];
    end
endmodule

// File: rtl/dstby_timer.sv
module dstby_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;
    logic [W:0]   nxt;

    assign nxt  = {1'b0, cnt} + (W+1)'(1);
    assign done = nxt >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (en)    cnt <= nxt[W-1:0];
    end
endmodule

// File: rtl/dstby_cause_reg.sv
module dstby_cause_reg
    import dstby_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cap,
    input  wake_cause_t          src,
    input  logic [CAUSE_W-1:0]   clr,
    output wake_cause_t          q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | (cap ? src : '0);
    end

    // R9: a bit only rises on a capture edge
    p_set_on_cap_r9: assert property (@(posedge clk) disable iff (rst)
        (|(q & ~$past(q))) |-> $past(cap));
endmodule

// File: rtl/dstby_wake_seq.sv
module dstby_wake_seq
    import dstby_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             standby_req,
    input  logic             rst_pin_n,
    input  logic             lvd_rst,
    input  logic             lvd_irq,
    input  logic             lvd_irq_ret_en,
    input  logic             lvd_irq_en,
    input  logic             wake_pin,
    input  logic             swdt_rst,
    input  logic             hwdt_rst,
    input  logic             csv_rst,
    input  logic             fdet_rst,
    input  logic [CNT_W-1:0] reg_settle_cycles,
    input  logic             hrc_ready,
    input  logic             lrc_ready,
    input  logic [1:0]       clk_mode_req,
    input  logic [3:0]       cause_clr,
    output logic             standby_o,
    output logic             reg_lp_mode,
    output logic             hrc_en,
    output logic             lrc_en,
    output logic             xfer_rst,
    output logic [1:0]       clk_sel,
    output logic             core_rst_req,
    output logic [3:0]       wake_cause
);
    localparam logic [3:0] SYNC_RST = 4'b0001;

    dstby_state_e state, state_nx;
    logic [3:0]   async_in, sync_q;
    wake_cause_t  srcs, cause_q;
    logic         wake_any, cap, set_force, force_hrc;
    logic         regw_done, xrst_done;

    assign async_in = {wake_pin, lvd_irq, lvd_rst, rst_pin_n};

    dstby_sync2 #(.W(4), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst(rst), .d(async_in), .q(sync_q)
    );

    always_comb begin
        srcs.pin_rst  = ~sync_q[0];
        srcs.lvd_rst  = sync_q[1];
        srcs.lvd_irq  = sync_q[2] & lvd_irq_ret_en & lvd_irq_en;
        srcs.wake_pin = sync_q[3];
    end
    assign wake_any = cause_any(srcs);

    dstby_timer #(.W(CNT_W)) u_regw (
        .clk(clk), .rst(rst), .clr(state != ST_REGW), .en(state == ST_REGW),
        .limit(reg_settle_cycles), .done(regw_done)
    );

    dstby_timer #(.W(CNT_W)) u_xrst (
        .clk(clk), .rst(rst), .clr(state != ST_XRST), .en(state == ST_XRST),
        .limit(CNT_W'(XRST_CYC)), .done(xrst_done)
    );

    always_comb begin
        state_nx  = state;
        cap       = 1'b0;
        set_force = 1'b0;
        unique case (state)
            ST_RUN:  if (standby_req && !wake_any) state_nx = ST_STBY;
            ST_STBY: if (wake_any) begin
                         state_nx = ST_REGW;
                         cap      = 1'b1;
                     end
            ST_REGW: if (regw_done) state_nx = ST_OSCW;
            ST_OSCW: if (hrc_ready && lrc_ready) begin
                         state_nx  = ST_XRST;
                         set_force = 1'b1;
                     end
            ST_XRST: if (xrst_done) state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            force_hrc <= 1'b1;
        end else begin
            state <= state_nx;
            if (set_force)
                force_hrc <= 1'b1;
            else if (state == ST_RUN && clk_mode_req == CLK_HRC)
                force_hrc <= 1'b0;
        end
    end

    dstby_cause_reg u_cause (
        .clk(clk), .rst(rst), .cap(cap), .src(srcs), .clr(cause_clr), .q(cause_q)
    );

    assign wake_cause   = cause_q;
    assign standby_o    = (state == ST_STBY) || (state == ST_REGW) || (state == ST_OSCW);
    assign reg_lp_mode  = (state == ST_STBY);
    assign hrc_en       = !((state == ST_STBY) || (state == ST_REGW));
    assign lrc_en       = hrc_en;
    assign xfer_rst     = (state == ST_XRST);
    assign clk_sel      = force_hrc ? CLK_HRC : clk_mode_req;
    assign core_rst_req = (state == ST_RUN) && (swdt_rst || hwdt_rst || csv_rst || fdet_rst);

    // R1: an active wake source leaves standby on the next edge
    p_wake_go_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STBY && wake_any) |=> (state == ST_REGW));
    // R2: without a wake source standby is held
    p_stby_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STBY && !wake_any) |=> (state == ST_STBY));
    // R5: transition reset starts only after both oscillators reported ready
    p_osc_ready_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_rst) |-> $past(hrc_ready && lrc_ready));
    // R6: the transition reset pulse is four cycles wide
    p_xrst_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer_rst) |-> $past(xfer_rst, 4));
    // R7: fast RC is selected once the transition reset ends
    p_force_hrc_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer_rst) |-> (clk_sel == CLK_HRC));
    // R8: an entry request with a pending source is refused
    p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && wake_any) |=> (state == ST_RUN));
endmodule

// File: tb/dstby_wake_seq_tb_top.sv
module dstby_wake_seq_tb_top;
    localparam int CLK_P = 10;
    localparam int CW    = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic standby_req = 0, rst_pin_n = 1, lvd_rst = 0, lvd_irq = 0;
    logic lvd_irq_ret_en = 0, lvd_irq_en = 0, wake_pin = 0;
    logic swdt_rst = 0, hwdt_rst = 0, csv_rst = 0, fdet_rst = 0;
    logic [CW-1:0] reg_settle_cycles = 5;
    logic hrc_ready = 1, lrc_ready = 1;
    logic [1:0] clk_mode_req = 2'b10;
    logic [3:0] cause_clr = 0;
    logic standby_o, reg_lp_mode, hrc_en, lrc_en, xfer_rst, core_rst_req;
    logic [1:0] clk_sel;
    logic [3:0] wake_cause;

    always #(CLK_P/2) clk = ~clk;

    dstby_wake_seq #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .standby_req(standby_req), .rst_pin_n(rst_pin_n),
        .lvd_rst(lvd_rst), .lvd_irq(lvd_irq), .lvd_irq_ret_en(lvd_irq_ret_en),
        .lvd_irq_en(lvd_irq_en), .wake_pin(wake_pin), .swdt_rst(swdt_rst),
        .hwdt_rst(hwdt_rst), .csv_rst(csv_rst), .fdet_rst(fdet_rst),
        .reg_settle_cycles(reg_settle_cycles), .hrc_ready(hrc_ready),
        .lrc_ready(lrc_ready), .clk_mode_req(clk_mode_req), .cause_clr(cause_clr),
        .standby_o(standby_o), .reg_lp_mode(reg_lp_mode), .hrc_en(hrc_en),
        .lrc_en(lrc_en), .xfer_rst(xfer_rst), .clk_sel(clk_sel),
        .core_rst_req(core_rst_req), .wake_cause(wake_cause)
    );

    int n_chk = 0, n_bad = 0;
    string scen = "R10";

    // behavioural model: 0 run, 1 standby, 2 regulator wait, 3 osc wait, 4 xfer reset
    int m_st = 0, m_cnt = 0;
    bit [3:0] m_cause = 0;
    bit m_force = 1;
    bit s1_n = 1, s2_n = 1, s1_lr = 0, s2_lr = 0, s1_iq = 0, s2_iq = 0, s1_wk = 0, s2_wk = 0;

    task automatic model_step();
        if (rst) begin
            m_st = 0; m_cnt = 0; m_cause = 0; m_force = 1;
            s1_n = 1; s2_n = 1; s1_lr = 0; s2_lr = 0; s1_iq = 0; s2_iq = 0; s1_wk = 0; s2_wk = 0;
        end else begin
            bit irq_ok, any, cap, setf;
            bit [3:0] src;
            int nst;
            irq_ok = s2_iq && lvd_irq_ret_en && lvd_irq_en;
            src    = {s2_wk, irq_ok, s2_lr, !s2_n};
            any    = (src != 0);
            nst = m_st; cap = 0; setf = 0;
            if (m_st == 0 && standby_req && !any) nst = 1;
            else if (m_st == 1 && any) begin nst = 2; cap = 1; end
            else if (m_st == 2 && (m_cnt + 1) >= int'(reg_settle_cycles)) nst = 3;
            else if (m_st == 3 && hrc_ready && lrc_ready) begin nst = 4; setf = 1; end
            else if (m_st == 4 && (m_cnt + 1) >= 4) nst = 0;
            m_cnt   = (nst != m_st) ? 0 : m_cnt + 1;
            m_cause = (m_cause & ~cause_clr) | (cap ? src : 4'b0);
            if (setf) m_force = 1;
            else if (m_st == 0 && clk_mode_req == 2'b00) m_force = 0;
            m_st = nst;
            s2_n = s1_n; s2_lr = s1_lr; s2_iq = s1_iq; s2_wk = s1_wk;
            s1_n = rst_pin_n; s1_lr = lvd_rst; s1_iq = lvd_irq; s1_wk = wake_pin;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, scen, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit osc_exp;
        osc_exp = (m_st == 0 || m_st == 3 || m_st == 4);
        chk("R6", "standby_o", standby_o, (m_st >= 1 && m_st <= 3));
        chk("R4", "reg_lp_mode", reg_lp_mode, (m_st == 1));
        chk("R5", "hrc_en", hrc_en, osc_exp);
        chk("R5", "lrc_en", lrc_en, osc_exp);
        chk("R6", "xfer_rst", xfer_rst, (m_st == 4));
        chk("R7", "clk_sel", clk_sel, m_force ? 0 : clk_mode_req);
        chk("R2", "core_rst_req", core_rst_req,
            (m_st == 0) && (swdt_rst || hwdt_rst || csv_rst || fdet_rst));
        chk("R9", "wake_cause", wake_cause, m_cause);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1 model_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic enter_stby();
        standby_req = 1; cyc(1);
        standby_req = 0; cyc(2);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        cyc(3);
        rst = 0;
        cyc(2);
        chk("R10", "reset standby", standby_o, 0);
        chk("R10", "reset clk_sel", clk_sel, 0);
        chk("R10", "reset cause", wake_cause, 0);
        chk("R10", "reset osc", hrc_en, 1);

        scen = "R2 run";
        swdt_rst = 1; cyc(1);
        chk("R2", "core reset in run", core_rst_req, 1);
        swdt_rst = 0; fdet_rst = 1; cyc(1); fdet_rst = 0;

        scen = "R7 mode";
        clk_mode_req = 2'b00; cyc(1);
        clk_mode_req = 2'b10; cyc(1);
        chk("R7", "mode follows", clk_sel, 2);

        scen = "R1 wake pin";
        reg_settle_cycles = 5; hrc_ready = 0; lrc_ready = 0;
        enter_stby();
        chk("R4", "low power reg", reg_lp_mode, 1);
        swdt_rst = 1; hwdt_rst = 1; csv_rst = 1; fdet_rst = 1; cyc(6);
        chk("R2", "masked stays", standby_o, 1);
        chk("R2", "masked core", core_rst_req, 0);
        swdt_rst = 0; hwdt_rst = 0; csv_rst = 0; fdet_rst = 0; cyc(1);
        wake_pin = 1; cyc(1); wake_pin = 0; cyc(2);
        chk("R1", "left standby", reg_lp_mode, 0);
        cyc(8);
        hrc_ready = 1; cyc(3);
        chk("R5", "one osc only", xfer_rst, 0);
        lrc_ready = 1; cyc(1);
        chk("R6", "xfer start", xfer_rst, 1);
        chk("R6", "standby dropped", standby_o, 0);
        cyc(4);
        chk("R7", "forced hrc", clk_sel, 0);
        chk("R9", "cause wake", wake_cause, 4'b1000);
        cause_clr = 4'b1000; cyc(1); cause_clr = 0; cyc(1);
        chk("R9", "cause cleared", wake_cause, 0);

        scen = "R1 reset pin";
        reg_settle_cycles = 0;
        enter_stby();
        rst_pin_n = 0; cyc(4); rst_pin_n = 1; cyc(10);
        chk("R1", "pin cause", wake_cause[0], 1);

        scen = "R1 lvd reset";
        reg_settle_cycles = 1;
        enter_stby();
        lvd_rst = 1; cyc(1); lvd_rst = 0; cyc(12);
        chk("R1", "lvd cause", wake_cause[1], 1);
        cause_clr = 4'b1111; cyc(1); cause_clr = 0;

        scen = "R3 irq";
        reg_settle_cycles = 3;
        enter_stby();
        lvd_irq = 1; lvd_irq_en = 1; lvd_irq_ret_en = 0; cyc(6);
        chk("R3", "ret_en off", standby_o, 1);
        lvd_irq_ret_en = 1; lvd_irq_en = 0; cyc(6);
        chk("R3", "irq_en off", reg_lp_mode, 1);
        lvd_irq_en = 1; cyc(12);
        chk("R3", "irq cause", wake_cause[2], 1);
        lvd_irq = 0; cyc(3);

        scen = "R8 refuse";
        wake_pin = 1; cyc(3);
        standby_req = 1; cyc(1); standby_req = 0; cyc(3);
        chk("R8", "refused", standby_o, 0);
        wake_pin = 0; cyc(3);
        lvd_irq = 1; lvd_irq_en = 0; lvd_irq_ret_en = 0; cyc(3);
        enter_stby();
        chk("R8", "disabled irq accepted", standby_o, 1);
        lvd_irq = 0;

        scen = "R9 clear vs set";
        cause_clr = 4'b1111;
        wake_pin = 1; cyc(3);
        chk("R9", "set wins", wake_cause[3], 1);
        cyc(1);
        chk("R9", "then cleared", wake_cause[3], 0);
        wake_pin = 0; cause_clr = 0; cyc(12);
        chk("R6", "back to run", standby_o, 0);

        finish_run();
    end
endmodule